// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the head of a receive path and looks only at the first six octets of each incoming frame, which carry the destination address. It sorts that address into one of three classes and decides whether the frame is kept. The all-ones address is the broadcast class. An address with its group bit set, or any address when hash-everything mode is on, is looked up in a 64-entry hash table. Any other address is compared against the programmed station address. The block raises a one-cycle decision pulse carrying two flags. The first says whether the frame is kept. The second says whether it failed the address test.

Octets arrive one per cycle with a valid strobe. A start marker flags the first octet and an end marker flags the last. The CRC for the hash is built one octet per cycle by an unrolled eight-step bit-serial engine. Three inputs set the filter mode: promiscuous, broadcast rejection and hash-everything. These mode bits, the station address and the hash table are captured when the start marker is seen, so host writes made later in the frame do not change its outcome. Octets after the sixth are not examined.

Top module: `rx_addr_filter`

## Requirements
- R1: While reset is high, and on the first cycle after reset is released, `dec_vld` is 0. Reset is synchronous and active high.
- R2: A destination of six 0xFF octets is a miss only when `mode_rej_bcast` is 1. Otherwise it is a hit.
- R3: The hash path is taken when bit 0 of the first destination octet is 1, or when `mode_all_hash` is 1, unless the address is broadcast. The hash is a 32-bit CRC seeded with all ones. It consumes the six octets in arrival order, least significant bit of each octet first. At each bit step the feedback is CRC bit 31 XOR the data bit. The CRC is then shifted left by one. When the feedback is 1, the CRC is XORed with 0x04C11DB6 and bit 0 is forced to 1.
- R4: The table index is CRC bits 31:26. Index bit 5 chooses `hash_word1` (when 1) or `hash_word0` (when 0), and index bits 4:0 choose the bit within that word. A 0 bit is a miss.
- R5: On the unicast path, destination octets 0 and 1 must equal `station_hi[15:8]` and `station_hi[7:0]`. Octets 2 to 5 must equal `station_lo[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`. Any difference is a miss.
- R6: A frame whose end marker arrives before its sixth octet is a miss.
- R7: `dec_accept` is 1 for a hit. For a miss it equals the promiscuous mode bit. `dec_miss` is 1 exactly for a miss.
- R8: `dec_vld` pulses for one cycle, exactly once per frame. For a frame of six or more octets, the pulse comes on the cycle after the sixth octet is presented. For a shorter frame, it comes on the cycle after the octet that carries the end marker. Octets past the sixth, and their end marker, cause no further pulse.
- R9: The mode bits, station address and hash table in effect are those present on the start-marker octet. Changes to them during the frame do not alter its decision.
- R10: A start marker seen in the middle of a frame abandons that frame without a decision and begins a new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Octet on `in_data` is valid this cycle |
| in_sof | input | 1 | This octet is the first of a frame |
| in_eof | input | 1 | This octet is the last of a frame |
| in_data | input | 8 | Received octet |
| mode_promisc | input | 1 | Keep frames that miss, with the miss flag set |
| mode_rej_bcast | input | 1 | Treat the broadcast address as a miss |
| mode_all_hash | input | 1 | Send every non-broadcast address through the hash table |
| station_hi | input | 16 | Station address octets 0 (bits 15:8) and 1 (bits 7:0) |
| station_lo | input | 32 | Station address octets 2 (bits 31:24) to 5 (bits 7:0) |
| hash_word0 | input | 32 | Hash table entries 0 to 31 |
| hash_word1 | input | 32 | Hash table entries 32 to 63 |
| dec_vld | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame is kept |
| dec_miss | output | 1 | Destination failed the address test |

## Verification
The bench targets the following corner cases:
- A frame that ends exactly on its sixth octet must give a single decision. A design that confused the two end conditions would give two pulses or none.
- One-octet and four-octet frames must be classed as misses. A design that dropped them would never pulse.
- Hash tables holding only the indexed bit, or every bit except it, show whether the CRC bit order, the seed, the bit-0 feedback and the choice of word are right. A design wrong in any of these would pick a different entry and flip the result.
- The station address is changed mid-frame, and a restart marker is sent mid-frame. A design that read the live registers late, or carried stale match state over a restart, would decide the frame on the wrong data.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // Filter mode bits captured per frame
  typedef struct packed {
    logic promisc;
    logic rej_bcast;
    logic all_hash;
  } rxf_mode_t;

  // Address classification used by the decision stage
  typedef enum logic [1:0] {
    CLS_BCAST = 2'd0,
    CLS_HASH  = 2'd1,
    CLS_UCAST = 2'd2,
    CLS_SHORT = 2'd3
  } rxf_class_e;

endpackage

// File: rtl/rxf_cfg_snap.sv
module rxf_cfg_snap
  import rxf_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned TBL_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              busy,
  input  rxf_mode_t         mode_live,
  input  logic [ADDR_W-1:0] sta_live,
  input  logic [TBL_W-1:0]  tbl_live,
  output rxf_mode_t         mode_eff,
  output logic [ADDR_W-1:0] sta_eff,
  output logic [TBL_W-1:0]  tbl_eff,
  output rxf_mode_t         mode_held
);

  rxf_mode_t         mode_q;
  logic [ADDR_W-1:0] sta_q;
  logic [TBL_W-1:0]  tbl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      sta_q  <= '0;
      tbl_q  <= '0;
    end else if (load) begin
      mode_q <= mode_live;
      sta_q  <= sta_live;
      tbl_q  <= tbl_live;
    end
  end

  // The start octet itself sees the live values; later octets see the copy
  assign mode_eff  = load ? mode_live : mode_q;
  assign sta_eff   = load ? sta_live  : sta_q;
  assign tbl_eff   = load ? tbl_live  : tbl_q;
  assign mode_held = mode_q;

  a_r9_snapshot_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && !load) |=> ($stable(mode_q) && $stable(sta_q) && $stable(tbl_q)));

endmodule

// File: rtl/rxf_byte_track.sv
module rxf_byte_track #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned CNT_W      = $clog2(ADDR_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic             sof,
  input  logic             eof,
  output logic             take,
  output logic             first,
  output logic             last,
  output logic             short_end,
  output logic             busy,
  output logic [CNT_W-1:0] pos
);

  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(ADDR_BYTES - 1);

  logic             act_q;
  logic [CNT_W-1:0] cnt_q;

  assign first     = vld && sof;
  assign take      = vld && (sof || act_q);
  assign pos       = first ? '0 : cnt_q;
  assign last      = take && (pos == LAST_POS);
  assign short_end = take && eof && !last;
  assign busy      = act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (take) begin
      if (last || eof) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        act_q <= 1'b1;
        cnt_q <= pos + CNT_W'(1);
      end
    end
  end

  a_r8_pos_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST_POS);

  a_r10_start_restarts: assert property (@(posedge clk) disable iff (rst)
    (vld && sof && !eof) |=> (act_q && cnt_q == CNT_W'(1)));

endmodule

// File: rtl/rxf_hash_crc.sv
module rxf_hash_crc #(
  parameter int unsigned          DATA_W   = 8,
  parameter int unsigned          CRC_W    = 32,
  parameter logic [CRC_W-1:0]     CRC_POLY = 32'h04C11DB6,
  parameter int unsigned          IDX_W    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              first,
  input  logic [DATA_W-1:0] data,
  output logic [IDX_W-1:0]  idx_next
);

  // One octet of the bit-serial hash CRC, LSB first, unrolled
  function automatic logic [CRC_W-1:0] crc_octet(input logic [CRC_W-1:0] c_in,
                                                 input logic [DATA_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = c_in;
    for (int i = 0; i < int'(DATA_W); i++) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = (c ^ CRC_POLY) | CRC_W'(1);
    end
    return c;
  endfunction

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_next;

  assign crc_next = crc_octet(first ? '1 : crc_q, data);
  assign idx_next = crc_next[CRC_W-1 -: IDX_W];

  always_ff @(posedge clk) begin
    if (rst)       crc_q <= '1;
    else if (take) crc_q <= crc_next;
  end

  a_r3_crc_holds_when_idle: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(crc_q));

endmodule

// File: rtl/rxf_match.sv
module rxf_match #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned CNT_W      = 3,
  parameter int unsigned ADDR_W     = DATA_W * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              first,
  input  logic [CNT_W-1:0]  pos,
  input  logic [DATA_W-1:0] data,
  input  logic [ADDR_W-1:0] sta_eff,
  output logic              bcast_n,
  output logic              ucast_n,
  output logic              grp_n
);

  logic              bc_q, uc_q, grp_q;
  logic [ADDR_W-1:0] sta_sh;
  logic [DATA_W-1:0] sta_byte;

  // Octet 0 of the address sits in the most significant octet of the station
  assign sta_sh   = sta_eff >> (DATA_W * (ADDR_BYTES - 1 - int'(pos)));
  assign sta_byte = sta_sh[DATA_W-1:0];

  assign bcast_n = (first || bc_q) && (data == '1);
  assign ucast_n = (first || uc_q) && (data == sta_byte);
  assign grp_n   = first ? data[0] : grp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bc_q  <= 1'b0;
      uc_q  <= 1'b0;
      grp_q <= 1'b0;
    end else if (take) begin
      bc_q  <= bcast_n;
      uc_q  <= ucast_n;
      grp_q <= grp_n;
    end
  end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int unsigned      DATA_W     = 8,
  parameter int unsigned      ADDR_BYTES = 6,
  parameter int unsigned      STA_LO_W   = 32,
  parameter int unsigned      CRC_W      = 32,
  parameter logic [CRC_W-1:0] CRC_POLY   = 32'h04C11DB6,
  parameter int unsigned      IDX_W      = 6
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           in_vld,
  input  logic                           in_sof,
  input  logic                           in_eof,
  input  logic [DATA_W-1:0]              in_data,
  input  logic                           mode_promisc,
  input  logic                           mode_rej_bcast,
  input  logic                           mode_all_hash,
  input  logic [DATA_W*ADDR_BYTES-STA_LO_W-1:0] station_hi,
  input  logic [STA_LO_W-1:0]            station_lo,
  input  logic [(2**IDX_W)/2-1:0]        hash_word0,
  input  logic [(2**IDX_W)/2-1:0]        hash_word1,
  output logic                           dec_vld,
  output logic                           dec_accept,
  output logic                           dec_miss
);

  localparam int unsigned ADDR_W = DATA_W * ADDR_BYTES;
  localparam int unsigned TBL_W  = 2 ** IDX_W;
  localparam int unsigned CNT_W  = $clog2(ADDR_BYTES);

  rxf_mode_t         mode_live, mode_eff, mode_held;
  logic [ADDR_W-1:0] sta_eff;
  logic [TBL_W-1:0]  tbl_eff;
  logic              take, first, last, short_end, busy;
  logic [CNT_W-1:0]  pos;
  logic [IDX_W-1:0]  idx_next;
  logic              bcast_n, ucast_n, grp_n;
  rxf_class_e        cls;
  logic              miss_n;

  assign mode_live = '{promisc: mode_promisc, rej_bcast: mode_rej_bcast,
                       all_hash: mode_all_hash};

  rxf_byte_track #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W)) u_track (
    .clk(clk), .rst(rst), .vld(in_vld), .sof(in_sof), .eof(in_eof),
    .take(take), .first(first), .last(last), .short_end(short_end),
    .busy(busy), .pos(pos)
  );

  rxf_cfg_snap #(.ADDR_W(ADDR_W), .TBL_W(TBL_W)) u_snap (
    .clk(clk), .rst(rst), .load(first), .busy(busy),
    .mode_live(mode_live), .sta_live({station_hi, station_lo}),
    .tbl_live({hash_word1, hash_word0}),
    .mode_eff(mode_eff), .sta_eff(sta_eff), .tbl_eff(tbl_eff),
    .mode_held(mode_held)
  );

  rxf_hash_crc #(.DATA_W(DATA_W), .CRC_W(CRC_W), .CRC_POLY(CRC_POLY), .IDX_W(IDX_W)) u_crc (
    .clk(clk), .rst(rst), .take(take), .first(first), .data(in_data),
    .idx_next(idx_next)
  );

  rxf_match #(.DATA_W(DATA_W), .ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_match (
    .clk(clk), .rst(rst), .take(take), .first(first), .pos(pos),
    .data(in_data), .sta_eff(sta_eff),
    .bcast_n(bcast_n), .ucast_n(ucast_n), .grp_n(grp_n)
  );

  // Classification: short frame, then broadcast, then hash, else unicast
  always_comb begin
    if (short_end)                         cls = CLS_SHORT;
    else if (bcast_n)                      cls = CLS_BCAST;
    else if (grp_n || mode_eff.all_hash)   cls = CLS_HASH;
    else                                   cls = CLS_UCAST;
    case (cls)
      CLS_SHORT: miss_n = 1'b1;
      CLS_BCAST: miss_n = mode_eff.rej_bcast;
      CLS_HASH:  miss_n = !tbl_eff[idx_next];
      default:   miss_n = !ucast_n;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_vld    <= 1'b0;
      dec_accept <= 1'b0;
      dec_miss   <= 1'b0;
    end else begin
      dec_vld <= last || short_end;
      if (last || short_end) begin
        dec_miss   <= miss_n;
        dec_accept <= !miss_n || mode_eff.promisc;
      end
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> !dec_vld);

  a_r7_hit_accepted: assert property (@(posedge clk) disable iff (rst)
    (dec_vld && !dec_miss) |-> dec_accept);

  a_r7_miss_dropped: assert property (@(posedge clk) disable iff (rst)
    (dec_vld && dec_miss && !mode_held.promisc) |-> !dec_accept);

  a_r8_idle_no_decision: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(in_vld && in_sof)) |=> !dec_vld);

endmodule

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;

  localparam int CLK_PERIOD      = 10;
  localparam int WATCHDOG_CYCLES = 50000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        mode_promisc = 1'b0, mode_rej_bcast = 1'b0, mode_all_hash = 1'b0;
  logic [15:0] station_hi = 16'h0;
  logic [31:0] station_lo = 32'h0;
  logic [31:0] hash_word0 = 32'h0, hash_word1 = 32'h0;
  logic        dec_vld, dec_accept, dec_miss;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .mode_promisc(mode_promisc), .mode_rej_bcast(mode_rej_bcast),
    .mode_all_hash(mode_all_hash), .station_hi(station_hi), .station_lo(station_lo),
    .hash_word0(hash_word0), .hash_word1(hash_word1),
    .dec_vld(dec_vld), .dec_accept(dec_accept), .dec_miss(dec_miss)
  );

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R1";
  bit    started = 0;
  int    cycles = 0;
  int    n_dec = 0;
  bit    last_acc = 0, last_miss = 0;
  logic [47:0] addr_g = 48'h0;

  // Reference model state
  bit          m_act = 0;
  int          m_cnt = 0;
  logic [47:0] m_addr = 48'h0;
  bit          m_pro = 0, m_rej = 0, m_all = 0;
  logic [47:0] m_sta = 48'h0;
  logic [63:0] m_tbl = 64'h0;
  bit          e_vld = 0, e_acc = 0, e_miss = 0;

  // Hash index per R3/R4: CRC over octets 0..5, LSB first
  function automatic int ref_hash_idx(input logic [47:0] a);
    logic [31:0] crc;
    logic [7:0]  b;
    bit          fb;
    crc = 32'hFFFFFFFF;
    for (int k = 0; k < 6; k++) begin
      b = a[47-8*k -: 8];
      for (int j = 0; j < 8; j++) begin
        fb  = crc[31] ^ b[j];
        crc = crc << 1;
        if (fb) crc = (crc ^ 32'h04C11DB6) | 32'h1;
      end
    end
    return int'(crc[31:26]);
  endfunction

  function automatic logic [7:0] frame_byte(input int i);
    if (i < 6) return addr_g[47-8*i -: 8];
    return 8'hA0 + 8'(i);
  endfunction

  // Behavioural reference model
  always @(posedge clk) begin
    bit miss;
    started <= 1'b1;
    cycles  <= cycles + 1;
    if (rst) begin
      m_act = 0; m_cnt = 0; e_vld = 0; e_acc = 0; e_miss = 0;
    end else begin
      e_vld = 0;
      if (in_vld) begin
        if (in_sof) begin
          m_act = 1; m_cnt = 0;
          m_pro = mode_promisc; m_rej = mode_rej_bcast; m_all = mode_all_hash;
          m_sta = {station_hi, station_lo};
          m_tbl = {hash_word1, hash_word0};
        end
        if (m_act) begin
          m_addr[47-8*m_cnt -: 8] = in_data;
          m_cnt++;
          if (m_cnt == 6) begin
            if (m_addr == 48'hFFFFFFFFFFFF)      miss = m_rej;
            else if (m_addr[40] || m_all)        miss = !m_tbl[ref_hash_idx(m_addr)];
            else                                 miss = (m_addr != m_sta);
            e_vld = 1; e_miss = miss; e_acc = !miss || m_pro; m_act = 0;
          end else if (in_eof) begin
            e_vld = 1; e_miss = 1; e_acc = m_pro; m_act = 0;
          end
        end
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (dec_vld !== e_vld || (e_vld && (dec_accept !== e_acc || dec_miss !== e_miss))) begin
        failures++;
        $display("FAIL %s per-cycle: vld=%b accept=%b miss=%b expected vld=%b accept=%b miss=%b",
                 cur_req, dec_vld, dec_accept, dec_miss, e_vld, e_acc, e_miss);
      end
      if (dec_vld === 1'b1) begin
        n_dec++; last_acc = dec_accept; last_miss = dec_miss;
      end
    end
  end

  task automatic drive_byte(input logic [7:0] d, input bit s, input bit e);
    @(posedge clk); #1;
    in_vld = 1'b1; in_sof = s; in_eof = e; in_data = d;
  endtask

  task automatic go_idle();
    @(posedge clk); #1;
    in_vld = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00;
  endtask

  task automatic send_frame(input int len, input string req);
    cur_req = req;
    n_dec = 0;
    for (int i = 0; i < len; i++) drive_byte(frame_byte(i), i == 0, i == len - 1);
    go_idle();
    repeat (2) @(posedge clk);
  endtask

  task automatic expect_dec(input string req, input bit acc, input bit miss);
    #2;
    checks++;
    if (n_dec != 1 || last_acc !== acc || last_miss !== miss) begin
      failures++;
      $display("FAIL %s: decisions=%0d accept=%b miss=%b expected decisions=1 accept=%b miss=%b",
               req, n_dec, last_acc, last_miss, acc, miss);
    end
  endtask

  task automatic set_mode(input bit p, input bit rb, input bit ah);
    mode_promisc = p; mode_rej_bcast = rb; mode_all_hash = ah;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // Watchdog
  always @(posedge clk) begin
    if (cycles > WATCHDOG_CYCLES) begin
      failures++;
      $display("FAIL R8 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [63:0] tbl;
    int          hi;
    cur_req = "R1";
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (dec_vld !== 1'b0) begin
      failures++;
      $display("FAIL R1: dec_vld=%b expected 0", dec_vld);
    end
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    checks++;
    if (dec_vld !== 1'b0) begin
      failures++;
      $display("FAIL R1: dec_vld=%b expected 0 after release", dec_vld);
    end

    station_hi = 16'h0211; station_lo = 32'h22334455;

    // R2: broadcast
    addr_g = 48'hFFFFFFFFFFFF;
    set_mode(0, 0, 0); send_frame(6, "R2"); expect_dec("R2", 1, 0);
    set_mode(0, 1, 0); send_frame(9, "R2"); expect_dec("R2", 0, 1);
    set_mode(1, 1, 0); send_frame(7, "R7"); expect_dec("R7", 1, 1);

    // R5: unicast compare and octet order
    set_mode(0, 0, 0);
    addr_g = 48'h021122334455; send_frame(10, "R5"); expect_dec("R5", 1, 0);
    addr_g = 48'h021122334454; send_frame(10, "R5"); expect_dec("R5", 0, 1);
    addr_g = 48'h110222334455; send_frame(8, "R5");  expect_dec("R5", 0, 1);
    set_mode(1, 0, 0);
    addr_g = 48'h021122334456; send_frame(8, "R7");  expect_dec("R7", 1, 1);

    // R3/R4: group address through the hash table
    set_mode(0, 0, 0);
    addr_g = 48'h01005E000001;
    tbl = 64'd1 << ref_hash_idx(addr_g);
    {hash_word1, hash_word0} = tbl;
    send_frame(8, "R4"); expect_dec("R4", 1, 0);
    {hash_word1, hash_word0} = ~tbl;
    send_frame(8, "R4"); expect_dec("R4", 0, 1);
    addr_g = 48'h3300AA55C3F1;
    tbl = 64'd1 << ref_hash_idx(addr_g);
    {hash_word1, hash_word0} = tbl;
    send_frame(6, "R4"); expect_dec("R4", 1, 0);

    // R3: hash-everything overrides a station match
    addr_g = 48'h021122334455;
    set_mode(0, 0, 1);
    {hash_word1, hash_word0} = ~(64'd1 << ref_hash_idx(addr_g));
    send_frame(8, "R3"); expect_dec("R3", 0, 1);
    {hash_word1, hash_word0} = 64'd1 << ref_hash_idx(addr_g);
    send_frame(8, "R3"); expect_dec("R3", 1, 0);
    hi = ref_hash_idx(addr_g);
    {hash_word1, hash_word0} = 64'd1 << (hi ^ 32);
    send_frame(8, "R4"); expect_dec("R4", 0, 1);

    // R6: short frames
    set_mode(0, 0, 0);
    addr_g = 48'h021122334455;
    send_frame(4, "R6"); expect_dec("R6", 0, 1);
    send_frame(1, "R6"); expect_dec("R6", 0, 1);
    set_mode(1, 0, 0);
    send_frame(5, "R6"); expect_dec("R6", 1, 1);

    // R9: mid-frame configuration change is not seen
    set_mode(0, 0, 0);
    addr_g = 48'h021122334455;
    fork
      send_frame(8, "R9");
      begin
        repeat (3) @(posedge clk);
        #2; station_lo = 32'h0; mode_rej_bcast = 1'b1; mode_all_hash = 1'b1;
      end
    join
    expect_dec("R9", 1, 0);
    station_lo = 32'h22334455; set_mode(0, 0, 0);

    // R10: restart marker mid-frame
    cur_req = "R10";
    n_dec = 0;
    drive_byte(8'h02, 1, 0); drive_byte(8'h11, 0, 0); drive_byte(8'h22, 0, 0);
    drive_byte(8'h33, 0, 0);
    for (int i = 0; i < 6; i++) drive_byte(8'hFF, i == 0, i == 5);
    go_idle(); repeat (2) @(posedge clk);
    expect_dec("R10", 1, 0);

    // R8: back-to-back frames, one decision each
    cur_req = "R8";
    n_dec = 0;
    addr_g = 48'h021122334455;
    for (int f = 0; f < 3; f++)
      for (int i = 0; i < 7; i++) drive_byte(frame_byte(i), i == 0, i == 6);
    go_idle(); repeat (2) @(posedge clk);
    #2;
    checks++;
    if (n_dec != 3) begin
      failures++;
      $display("FAIL R8: decisions=%0d expected 3", n_dec);
    end

    // Random frames against the reference model
    for (int f = 0; f < 60; f++) begin
      int sel;
      sel = int'($urandom % 4);
      case (sel)
        0: addr_g = 48'hFFFFFFFFFFFF;
        1: addr_g = {16'($urandom) | 16'h0100, 32'($urandom)};
        2: addr_g = {station_hi, station_lo};
        default: addr_g = {16'($urandom), 32'($urandom)};
      endcase
      set_mode(1'($urandom), 1'($urandom), 1'($urandom));
      hash_word0 = $urandom; hash_word1 = $urandom;
      send_frame(1 + int'($urandom % 10), "R4");
      #2;
      checks++;
      if (n_dec != 1) begin
        failures++;
        $display("FAIL R8: decisions=%0d expected 1", n_dec);
      end
    end

    summary();
    $finish;
  end

endmodule